// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block holds the feedback-divider setting (M, six bits) and the output-divider setting (N, two bits) of a clock synthesizer and loads them from a three-wire serial port. The port has a data line, a shift clock and a load strobe. A second, active-low parallel-load input lets the two settings be driven directly from parallel pins. All port inputs are asynchronous to the block. They pass through two-flop synchronizers into a fast system clock, and edges are found there. The system clock must run at least four times faster than the shift clock.

The load strobe has three roles. Its rising edge copies the shift register into the divider outputs. Its falling edge freezes the outputs. While it stays high, the outputs follow the shift register after every shift. A one-cycle update pulse flags every change of the outputs, so the downstream dividers know to reload.

A controller moves between three states. ST_SHIFT is the frozen state: the outputs hold and the register shifts. ST_PASS is the transparent state. ST_PAR is the parallel state. The transitions are:
- load-rise: ST_SHIFT to ST_PASS.
- load-fall: ST_PASS to ST_SHIFT.
- par-enter: ST_SHIFT or ST_PASS to ST_PAR, taken when the parallel input goes low.
- par-exit: ST_PAR to ST_PASS when the strobe is high, or to ST_SHIFT when it is low.

Top module: `divcfg_serial_port`

## Requirements
- R1: With the parallel input inactive, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 14-bit shift register, and the older bits move up one place.
- R2: The frame is 14 bits long and its first bit is sent first. Bit order on the wire:
  - two zero bits;
  - one ignored bit;
  - N[1];
  - N[0];
  - three ignored bits;
  - M[5] down to M[0].
  
  After 14 shifts, N occupies register bits 10:9 and M occupies bits 5:0. The ignored bits never reach the outputs.
- R3: A rising edge of `ser_load` copies the register fields to `m_out` and `n_out`.
- R4: A falling edge of `ser_load` freezes `m_out` and `n_out`. Shifts that follow while the strobe is low do not change them.
- R5: While `ser_load` stays high, every `ser_clk` rising edge updates `m_out` and `n_out` from the newly shifted register.
- R6: When a shift-clock rising edge and a strobe rising edge are seen in the same system cycle, the shift is applied first. The transfer then carries the shifted contents.
- R7: A high level on `mreset` clears the shift register, `m_out`, `n_out` and `div_update` to zero.
- R8: While `par_load_n` is low, `m_out` and `n_out` follow `par_m` and `par_n`, and the values present at its release are kept. While it is low, shift-clock and strobe edges leave the shift register and outputs unchanged.
- R9: `div_update` is high for exactly the one cycle in which `m_out` or `n_out` takes a new value. It stays low when a transfer leaves the values as they were.
- R10: A port transition shows on the outputs at the third rising system-clock edge after it: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the shift clock |
| mreset | input | 1 | Master reset, active high, asynchronous |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data line |
| ser_load | input | 1 | Load strobe |
| par_load_n | input | 1 | Parallel load enable, active low |
| par_m | input | 6 | Parallel feedback-divider value |
| par_n | input | 2 | Parallel output-divider code (0: divide by 1, N[1]=1: divide by 4) |
| m_out | output | 6 | Feedback-divider setting |
| n_out | output | 2 | Output-divider setting |
| div_update | output | 1 | One-cycle pulse when a setting changes |

## Verification
Every port transition takes effect on the third rising system-clock edge after it. The update pulse is high only in the cycle that follows that edge. The bench changes inputs on falling edges. It checks one strobe transfer on the exact cycle, reading the old value after two edges and the new value and the pulse after three. Every other check waits six system cycles before sampling, so that check does not depend on the latency.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_PASS  = 2'd1,
        ST_PAR   = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
                prev_q <= RST_VAL[i];
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign lvl[i]  = sync_q;
        assign rise[i] = sync_q & ~prev_q;
        assign fall[i] = ~sync_q & prev_q;
    end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
    parameter int SR_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] sr_next
);
    always_comb begin
        sr_next = sr_q;
        if (shift_en) sr_next = {sr_q[SR_W-2:0], bit_in};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_next;
    end

    // R1: a shift moves the older bits up by one place
    assert_shift_moves_R1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0])));
endmodule

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
    import divcfg_pkg::*;
#(
    parameter int SR_W  = 14,
    parameter int M_W   = 6,
    parameter int N_W   = 2,
    parameter int M_LSB = 0,
    parameter int N_LSB = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_lvl,
    input  logic            load_rise,
    input  logic            load_fall,
    input  logic            sclk_rise,
    input  logic            par_act,
    input  logic [M_W-1:0]  par_m,
    input  logic [N_W-1:0]  par_n,
    input  logic [SR_W-1:0] sr_q,
    input  logic [SR_W-1:0] sr_next,
    output logic            shift_en,
    output logic [M_W-1:0]  m_out,
    output logic [N_W-1:0]  n_out,
    output logic            upd
);
    cfg_state_e st_q, st_d;
    logic [M_W-1:0] m_d;
    logic [N_W-1:0] n_d;

    assign shift_en = sclk_rise && !par_act;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SHIFT: begin
                if (par_act)        st_d = ST_PAR;
                else if (load_rise) st_d = ST_PASS;
            end
            ST_PASS: begin
                if (par_act)        st_d = ST_PAR;
                else if (load_fall) st_d = ST_SHIFT;
            end
            ST_PAR: begin
                if (!par_act)       st_d = load_lvl ? ST_PASS : ST_SHIFT;
            end
            default:                st_d = ST_SHIFT;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= ST_SHIFT;
        else     st_q <= st_d;
    end

    always_comb begin
        m_d = m_out;
        n_d = n_out;
        if (par_act) begin
            m_d = par_m;
            n_d = par_n;
        end else begin
            unique case (st_q)
                ST_SHIFT: if (load_rise) begin
                    m_d = sr_next[M_LSB +: M_W];
                    n_d = sr_next[N_LSB +: N_W];
                end
                ST_PASS: if (load_lvl && sclk_rise) begin
                    m_d = sr_next[M_LSB +: M_W];
                    n_d = sr_next[N_LSB +: N_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            m_out <= '0;
            n_out <= '0;
            upd   <= 1'b0;
        end else begin
            m_out <= m_d;
            n_out <= n_d;
            upd   <= ({m_d, n_d} != {m_out, n_out});
        end
    end

    assert_transfer_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && load_rise && !par_act) |=>
        (m_out == sr_q[M_LSB +: M_W] && n_out == sr_q[N_LSB +: N_W]));

    assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && !load_rise && !par_act) |=>
        ($stable(m_out) && $stable(n_out)));

    assert_track_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PASS && load_lvl && sclk_rise && !par_act) |=>
        (m_out == sr_q[M_LSB +: M_W] && n_out == sr_q[N_LSB +: N_W]));

    assert_par_follow_R8: assert property (@(posedge clk) disable iff (rst)
        par_act |=> (m_out == $past(par_m) && n_out == $past(par_n)));

    assert_par_noshift_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAR && par_act) |=> $stable(sr_q));

    assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable({m_out, n_out}) |-> upd);

    assert_pulse_only_change_R9: assert property (@(posedge clk) disable iff (rst)
        upd |-> !$stable({m_out, n_out}));
endmodule

// File: rtl/divcfg_serial_port.sv
module divcfg_serial_port #(
    parameter int M_W      = 6,
    parameter int N_W      = 2,
    parameter int LEAD_W   = 2,
    parameter int PAD_HI_W = 1,
    parameter int PAD_LO_W = 3
) (
    input  logic           clk,
    input  logic           mreset,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic           div_update
);
    localparam int SR_W  = LEAD_W + PAD_HI_W + N_W + PAD_LO_W + M_W;
    localparam int M_LSB = 0;
    localparam int N_LSB = M_W + PAD_LO_W;
    localparam int IN_W  = 4;

    logic [IN_W-1:0] s_lvl, s_rise, s_fall;
    logic [SR_W-1:0] sr_q, sr_next;
    logic            shift_en;

    divcfg_sync #(.W(IN_W), .RST_VAL(4'b1000)) u_sync (
        .clk      (clk),
        .rst      (mreset),
        .async_in ({par_load_n, ser_load, ser_data, ser_clk}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    divcfg_shift #(.SR_W(SR_W)) u_shift (
        .clk      (clk),
        .rst      (mreset),
        .shift_en (shift_en),
        .bit_in   (s_lvl[1]),
        .sr_q     (sr_q),
        .sr_next  (sr_next)
    );

    divcfg_ctrl #(
        .SR_W(SR_W), .M_W(M_W), .N_W(N_W), .M_LSB(M_LSB), .N_LSB(N_LSB)
    ) u_ctrl (
        .clk       (clk),
        .rst       (mreset),
        .load_lvl  (s_lvl[2]),
        .load_rise (s_rise[2]),
        .load_fall (s_fall[2]),
        .sclk_rise (s_rise[0]),
        .par_act   (!s_lvl[3]),
        .par_m     (par_m),
        .par_n     (par_n),
        .sr_q      (sr_q),
        .sr_next   (sr_next),
        .shift_en  (shift_en),
        .m_out     (m_out),
        .n_out     (n_out),
        .upd       (div_update)
    );
endmodule

// File: tb/divcfg_serial_port_tb.sv
module divcfg_serial_port_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       mreset = 1'b1;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic       par_load_n = 1'b1;
    logic [5:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [5:0] m_out;
    logic [1:0] n_out;
    logic       div_update;

    int n_chk = 0, n_fail = 0, upd_cnt = 0;
    logic [13:0] sr_model = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    divcfg_serial_port u_dut (
        .clk(clk), .mreset(mreset), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
        .m_out(m_out), .n_out(n_out), .div_update(div_update)
    );

    always @(posedge clk) if (div_update) upd_cnt++;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic ser_bit(logic b);
        @(negedge clk); ser_data = b;
        repeat (4) @(negedge clk); ser_clk = 1'b1;
        repeat (4) @(negedge clk); ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        if (par_load_n) sr_model = {sr_model[12:0], b};
    endtask

    task automatic ser_frame(logic [5:0] m, logic [1:0] n);
        logic [13:0] f;
        f = {2'b00, 1'b1, n, 3'b111, m};
        for (int i = 13; i >= 0; i--) ser_bit(f[i]);
    endtask

    task automatic set_load(logic v);
        @(negedge clk); ser_load = v; settle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk); mreset = 1'b0; settle();
        chk("R7 reset m", m_out, 0);
        chk("R7 reset n", n_out, 0);
        chk("R7 reset upd", div_update, 0);
    endtask

    task automatic t_frame_transfer();
        int c0;
        ser_frame(6'h2D, 2'b10);
        chk("R4 no transfer while low m", m_out, 0);
        c0 = upd_cnt;
        @(negedge clk); ser_load = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 not yet after 2 edges", m_out, 0);
        @(negedge clk);
        chk("R10 R3 transfer m on 3rd edge", m_out, 6'h2D);
        chk("R2 R3 transfer n", n_out, 2'b10);
        chk("R9 pulse high", div_update, 1);
        @(negedge clk);
        chk("R9 pulse one cycle", div_update, 0);
        settle();
        chk("R9 pulse count", upd_cnt - c0, 1);
    endtask

    task automatic t_freeze();
        int c0;
        set_load(1'b0);
        c0 = upd_cnt;
        ser_frame(6'h13, 2'b01);
        chk("R4 frozen m", m_out, 6'h2D);
        chk("R4 frozen n", n_out, 2'b10);
        chk("R4 no pulse", upd_cnt - c0, 0);
        set_load(1'b1);
        chk("R1 R3 second frame m", m_out, 6'h13);
        chk("R2 second frame n", n_out, 2'b01);
    endtask

    task automatic t_transparent();
        ser_bit(1'b1);
        settle();
        chk("R5 track m", m_out, sr_model[5:0]);
        chk("R5 track n", n_out, sr_model[10:9]);
        ser_bit(1'b0);
        settle();
        chk("R5 track m again", m_out, sr_model[5:0]);
    endtask

    task automatic t_coincident();
        set_load(1'b0);
        ser_bit(1'b1); ser_bit(1'b0);
        @(negedge clk); ser_data = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1; ser_load = 1'b1;
        sr_model = {sr_model[12:0], 1'b1};
        repeat (4) @(negedge clk); ser_clk = 1'b0;
        settle();
        chk("R6 shift then transfer m", m_out, sr_model[5:0]);
        chk("R6 shift then transfer n", n_out, sr_model[10:9]);
    endtask

    task automatic t_parallel();
        @(negedge clk); par_m = 6'h15; par_n = 2'b01; par_load_n = 1'b0;
        settle();
        chk("R8 par m", m_out, 6'h15);
        chk("R8 par n", n_out, 2'b01);
        ser_bit(1'b1); ser_bit(1'b1);
        set_load(1'b0); set_load(1'b1);
        chk("R8 serial ignored m", m_out, 6'h15);
        @(negedge clk); par_m = 6'h2A; par_n = 2'b10; settle();
        chk("R8 par follow m", m_out, 6'h2A);
        @(negedge clk); par_load_n = 1'b1; settle();
        @(negedge clk); par_m = 6'h01; settle();
        chk("R8 kept after release", m_out, 6'h2A);
        set_load(1'b0); set_load(1'b1);
        chk("R8 register untouched m", m_out, sr_model[5:0]);
        chk("R8 register untouched n", n_out, sr_model[10:9]);
    endtask

    task automatic t_same_value();
        int c0;
        c0 = upd_cnt;
        set_load(1'b0); set_load(1'b1);
        chk("R9 no pulse on equal transfer", upd_cnt - c0, 0);
    endtask

    task automatic t_mreset();
        @(negedge clk); mreset = 1'b1; ser_load = 1'b0;
        @(negedge clk);
        chk("R7 mid reset m", m_out, 0);
        @(negedge clk); mreset = 1'b0; settle();
        sr_model = '0;
        set_load(1'b1);
        chk("R7 register cleared m", m_out, 0);
        chk("R7 register cleared n", n_out, 0);
    endtask

    initial begin
        t_reset();
        t_frame_transfer();
        t_freeze();
        t_transparent();
        t_coincident();
        t_parallel();
        t_same_value();
        t_mreset();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule